// File: doc/BRIEF.md
# Predication and Issue-Group Controller

This block sits right after block-header decode in an in-order front end. It takes the predication and parallelism fields of a decoded header, the current 16-bit flag register and the slot bounds of the block. It returns two things for each of the eight 32-bit instruction slots: whether the slot executes, and which issue group it belongs to. The compiler decides issue groups through explicit break bits, so no interlock logic takes part. A slot whose break bit is clear issues together with the slots before it.

Two header shapes are handled. The short shape takes one slot. It carries a single condition: a sense bit, a mask over the slots that follow, and a 3-bit flag selector, so only flags 0 to 7 can be named. The long shape takes two slots. It carries three independent conditions, each with a 4-bit selector that can name any of the 16 flags and its own sense bit. Two conditions may name the same flag with opposite senses.

The results are registered and appear one clock after the inputs.

Top module: `pc_issue_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `run_o` and `grp_o` are cleared to zero at that edge.
- R2: Header slots never execute and report group 0. In the short shape (`long_hdr_i`=0) this is slot 0. In the long shape (`long_hdr_i`=1) it is slots 0 and 1.
- R3: Slots with an index greater than `last_slot_i` are excluded. They never execute and report group 0. If `last_slot_i` is below the first instruction slot, no slot executes.
- R4: An included slot that no active condition marks always executes.
- R5: A slot marked by a condition runs only if the selected flag equals the inverse of that condition's sense bit. With sense 0 it needs the flag at 1. With sense 1 it needs the flag at 0.
- R6: In the short shape, only condition 0 is active. The flag index is `cond_sel_i[2:0]`, so bit 3 of the selector is ignored. The masks of conditions 1 and 2 have no effect.
- R7: In the long shape, all three conditions are active and each uses its full 4-bit selector. A slot marked by more than one condition runs only if every marking condition passes.
- R8: The first included slot is in group 0. Each later included slot whose break bit is 1 increases the group by one. Break bits of header slots, of excluded slots and of the first included slot are ignored.
- R9: Outputs are registered. A change on any input shows at the outputs after the next rising edge and not before it.

Field positions: condition k uses `cond_sel_i[4k+3:4k]`, `cond_inv_i[k]` and `cond_mask_i[8k+7:8k]`. Bit i of a mask, or of `brk_i`, refers to slot i. The group of slot i is `grp_o[3i+2:3i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_hdr_i | input | 1 | 0: one-slot header with one condition; 1: two-slot header with three conditions |
| last_slot_i | input | 3 | Index of the last slot holding an instruction |
| flags_i | input | 16 | Flag register |
| cond_sel_i | input | 12 | Flag selector per condition, 4 bits each |
| cond_inv_i | input | 3 | Sense bit per condition |
| cond_mask_i | input | 24 | Slot mask per condition, 8 bits each |
| brk_i | input | 8 | Break bit per slot |
| run_o | output | 8 | Execute enable per slot |
| grp_o | output | 24 | Issue-group number per slot, 3 bits each |

## Verification
Both results, the execute mask and the group numbers, pass through one register. They are due exactly one rising edge after the inputs settle. The bench drives every input on a falling edge and compares one full period later, on the next falling edge. It also looks at the outputs one nanosecond after driving, before any edge, to confirm that they still hold the previous values. Expected values come from an arithmetic model of the requirements. That model covers exhaustive sweeps of header shape, last slot and break pattern, plus a long pseudo-random walk over flags, selectors, senses and masks.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and types for the issue controller.
// Assumes eight 32-bit slots per block and a 16-bit flag register.
package pc_pkg;
    localparam int PC_NSLOT      = 8;   // slots per block
    localparam int PC_NSET       = 3;   // conditions in the long shape
    localparam int PC_FLAGW      = 16;  // flag register width
    localparam int PC_NARROW_W   = 3;   // selector bits used in the short shape
    localparam int PC_HDR_SHORT  = 1;   // slots taken by the short header
    localparam int PC_HDR_LONG   = 2;   // slots taken by the long header

    typedef enum logic {
        FORM_SHORT = 1'b0,
        FORM_LONG  = 1'b1
    } hdr_form_e;
endpackage

// File: rtl/pc_cond_set.sv
`timescale 1ns/1ps
// Module: one predicate condition evaluated against every slot.
// pass_o[i] is low only when the condition is active, marks slot i,
// and the selected flag does not meet the sense. In narrow mode only
// the low NARROW_W selector bits are used.
module pc_cond_set #(
    parameter int NSLOT    = 8,
    parameter int FLAGW    = 16,
    parameter int NARROW_W = 3,
    localparam int SELW    = $clog2(FLAGW)
) (
    input  logic [FLAGW-1:0] flags_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             inv_i,
    input  logic [NSLOT-1:0] mask_i,
    input  logic             active_i,
    input  logic             narrow_i,
    output logic [NSLOT-1:0] pass_o
);
    logic [SELW-1:0] eff_sel;
    logic            cond_ok;

    // Pick the flag index, truncated in narrow mode.
    assign eff_sel = narrow_i ? SELW'(sel_i[NARROW_W-1:0]) : sel_i;
    // The condition holds when the flag differs from the sense bit.
    assign cond_ok = flags_i[eff_sel] ^ inv_i;

    // A slot passes unless this active condition marks it and fails.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            pass_o[i] = !active_i || !mask_i[i] || cond_ok;
        end
    end
endmodule

// File: rtl/pc_grp_scan.sv
`timescale 1ns/1ps
// Module: issue-group numbering over the included slots.
// Assumes the included slots are contiguous. The first included slot
// opens group 0, and every later included slot with a break bit opens
// the next group. Excluded slots report 0.
module pc_grp_scan #(
    parameter int NSLOT = 8,
    localparam int GRPW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]      live_i,
    input  logic [NSLOT-1:0]      brk_i,
    output logic [NSLOT*GRPW-1:0] grp_o
);
    logic [GRPW-1:0] cnt;
    logic            seen;

    // Walk the slots in order, counting breaks after the first live slot.
    always_comb begin
        cnt  = '0;
        seen = 1'b0;
        grp_o = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (live_i[i]) begin
                if (seen && brk_i[i]) cnt = cnt + 1'b1;
                grp_o[i*GRPW +: GRPW] = cnt;
                seen = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pc_issue_ctrl.sv
`timescale 1ns/1ps
// Module: predication and issue-group controller (top).
// Combines the slot bounds, up to NSET predicate conditions and the
// break mask into a registered execute mask and per-slot group numbers.
// Assumes the decoded header fields are stable for one cycle per block.
module pc_issue_ctrl
    import pc_pkg::*;
#(
    parameter int NSLOT    = PC_NSLOT,
    parameter int NSET     = PC_NSET,
    parameter int FLAGW    = PC_FLAGW,
    parameter int NARROW_W = PC_NARROW_W,
    parameter int HDR_SHORT = PC_HDR_SHORT,
    parameter int HDR_LONG  = PC_HDR_LONG,
    localparam int IDXW    = $clog2(NSLOT),
    localparam int SELW    = $clog2(FLAGW),
    localparam int GRPW    = $clog2(NSLOT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  long_hdr_i,
    input  logic [IDXW-1:0]       last_slot_i,
    input  logic [FLAGW-1:0]      flags_i,
    input  logic [NSET*SELW-1:0]  cond_sel_i,
    input  logic [NSET-1:0]       cond_inv_i,
    input  logic [NSET*NSLOT-1:0] cond_mask_i,
    input  logic [NSLOT-1:0]      brk_i,
    output logic [NSLOT-1:0]      run_o,
    output logic [NSLOT*GRPW-1:0] grp_o
);
    hdr_form_e               form;
    logic [IDXW-1:0]         first_slot;
    logic [NSLOT-1:0]        live_d;
    logic [NSLOT-1:0]        pass_all;
    logic [NSLOT-1:0]        pass_set [NSET];
    logic [NSLOT-1:0]        run_d;
    logic [NSLOT*GRPW-1:0]   grp_d;

    assign form = hdr_form_e'(long_hdr_i);
    // First instruction slot follows the header.
    assign first_slot = (form == FORM_LONG) ? IDXW'(HDR_LONG) : IDXW'(HDR_SHORT);

    // Mark slots between the header and the last decoded slot.
    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_live
            assign live_d[s] = (IDXW'(s) >= first_slot) && (IDXW'(s) <= last_slot_i);
        end
    endgenerate

    // One evaluator per condition. Only condition 0 is active in the short shape.
    genvar k;
    generate
        for (k = 0; k < NSET; k++) begin : g_set
            pc_cond_set #(
                .NSLOT   (NSLOT),
                .FLAGW   (FLAGW),
                .NARROW_W(NARROW_W)
            ) u_set (
                .flags_i (flags_i),
                .sel_i   (cond_sel_i[k*SELW +: SELW]),
                .inv_i   (cond_inv_i[k]),
                .mask_i  (cond_mask_i[k*NSLOT +: NSLOT]),
                .active_i((k == 0) || (form == FORM_LONG)),
                .narrow_i(form == FORM_SHORT),
                .pass_o  (pass_set[k])
            );
        end
    endgenerate

    // A slot passes only when every condition lets it through.
    always_comb begin
        pass_all = '1;
        for (int j = 0; j < NSET; j++) pass_all = pass_all & pass_set[j];
    end

    assign run_d = live_d & pass_all;

    pc_grp_scan #(.NSLOT(NSLOT)) u_grp (
        .live_i(live_d),
        .brk_i (brk_i),
        .grp_o (grp_d)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= '0;
            grp_o <= '0;
        end else begin
            run_o <= run_d;
            grp_o <= grp_d;
        end
    end

    // Assertions.
    generate
        for (s = 0; s < NSLOT; s++) begin : g_chk
            if (s < HDR_LONG) begin : g_hdr
                p_hdr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    long_hdr_i |=> !run_o[s]);
            end
            if (s < HDR_SHORT) begin : g_hdr_s
                p_hdr_short_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    !long_hdr_i |=> !run_o[s]);
            end
            p_excluded_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (IDXW'(s) > last_slot_i) |=> (!run_o[s] && grp_o[s*GRPW +: GRPW] == '0));
            p_plain_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (live_d[s] && !cond_mask_i[s] &&
                 (!long_hdr_i || (!cond_mask_i[NSLOT+s] && !cond_mask_i[2*NSLOT+s])))
                |=> run_o[s]);
            p_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (live_d[s] && !long_hdr_i && cond_mask_i[s])
                |=> run_o[s] == ($past(flags_i[cond_sel_i[NARROW_W-1:0]]) ^ $past(cond_inv_i[0])));
            if (s > 0) begin : g_step
                p_grp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    (live_d[s] && live_d[s-1])
                    |=> (grp_o[s*GRPW +: GRPW] - grp_o[(s-1)*GRPW +: GRPW]) ==
                        GRPW'($past(brk_i[s])));
            end
        end
    endgenerate
endmodule

// File: tb/pc_issue_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: directed cases plus exhaustive and pseudo-random sweeps.
module pc_issue_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_hdr_i = 1'b0;
    logic [2:0]  last_slot_i = '0;
    logic [15:0] flags_i = '0;
    logic [11:0] cond_sel_i = '0;
    logic [2:0]  cond_inv_i = '0;
    logic [23:0] cond_mask_i = '0;
    logic [7:0]  brk_i = '0;
    logic [7:0]  run_o;
    logic [23:0] grp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pc_issue_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .long_hdr_i(long_hdr_i), .last_slot_i(last_slot_i),
        .flags_i(flags_i), .cond_sel_i(cond_sel_i), .cond_inv_i(cond_inv_i),
        .cond_mask_i(cond_mask_i), .brk_i(brk_i), .run_o(run_o), .grp_o(grp_o)
    );

    // Model: execute mask from the requirements.
    function automatic logic [7:0] exp_run();
        logic [7:0] r;
        int first;
        first = long_hdr_i ? 2 : 1;
        for (int i = 0; i < 8; i++) begin
            logic ok;
            ok = (i >= first) && (i <= int'(last_slot_i));
            for (int k = 0; k < 3; k++) begin
                if ((k == 0 || long_hdr_i) && cond_mask_i[8*k+i]) begin
                    int idx;
                    idx = long_hdr_i ? int'(cond_sel_i[4*k +: 4]) : int'(cond_sel_i[4*k +: 3]);
                    if (flags_i[idx] == cond_inv_i[k]) ok = 1'b0;
                end
            end
            r[i] = ok;
        end
        return r;
    endfunction

    // Model: group numbers from the requirements.
    function automatic logic [23:0] exp_grp();
        logic [23:0] g;
        int first, cnt;
        bit seen;
        g = '0; cnt = 0; seen = 1'b0;
        first = long_hdr_i ? 2 : 1;
        for (int i = 0; i < 8; i++) begin
            if (i >= first && i <= int'(last_slot_i)) begin
                if (seen && brk_i[i]) cnt++;
                g[3*i +: 3] = 3'(cnt);
                seen = 1'b1;
            end
        end
        return g;
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply inputs on a falling edge and check one period later.
    task automatic apply_and_check(input string req);
        logic [7:0]  er;
        logic [23:0] eg;
        logic [7:0]  prev;
        prev = run_o;
        er = exp_run();
        eg = exp_grp();
        #1;
        chk("R9 hold before edge", {16'h0, run_o}, {16'h0, prev});
        @(negedge clk);
        chk({req, " run"}, {16'h0, run_o}, {16'h0, er});
        chk({req, " grp"}, grp_o, eg);
    endtask

    task automatic clear_in();
        long_hdr_i = 0; last_slot_i = 3'd7; flags_i = '0; cond_sel_i = '0;
        cond_inv_i = '0; cond_mask_i = '0; brk_i = '0;
    endtask

    initial begin
        logic [31:0] lcg;
        // R1: drive nonzero inputs while reset is held.
        last_slot_i = 3'd7; brk_i = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 reset run", {16'h0, run_o}, 24'h0);
        chk("R1 reset grp", grp_o, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_in();

        // R2: header slots stay off in both shapes.
        @(negedge clk); apply_and_check("R2 short");
        chk("R2 short literal", {16'h0, run_o}, 24'h0000FE);
        long_hdr_i = 1; @(negedge clk); apply_and_check("R2 long");
        chk("R2 long literal", {16'h0, run_o}, 24'h0000FC);

        // R3: bounds on the last slot.
        long_hdr_i = 0; last_slot_i = 3'd3; brk_i = 8'hFF;
        apply_and_check("R3 short last3");
        chk("R3 literal", {16'h0, run_o}, 24'h00000E);
        long_hdr_i = 1; last_slot_i = 3'd1;
        apply_and_check("R3 long none");
        chk("R3 none literal", {16'h0, run_o} | grp_o, 24'h0);

        // R4 and R5: sense of one condition in the short shape.
        clear_in(); cond_mask_i[3] = 1; cond_sel_i[2:0] = 3'd5; flags_i[5] = 1;
        apply_and_check("R4/R5 sense0 flag1");
        chk("R5 run slot3", {23'h0, run_o[3]}, 24'h1);
        cond_inv_i[0] = 1; apply_and_check("R5 sense1 flag1");
        chk("R5 off slot3", {23'h0, run_o[3]}, 24'h0);

        // R6: selector bit 3 and extra conditions ignored in the short shape.
        clear_in(); cond_sel_i[3:0] = 4'd13; flags_i[5] = 1; flags_i[13] = 0;
        cond_mask_i[3] = 1; cond_mask_i[8+4] = 1; cond_mask_i[16+6] = 1;
        apply_and_check("R6 narrow");
        chk("R6 literal", {16'h0, run_o}, 24'h0000FE);

        // R7: opposite senses on one flag, and an AND of two conditions.
        clear_in(); long_hdr_i = 1;
        cond_sel_i = {4'd3, 4'd9, 4'd9}; cond_inv_i = 3'b010;
        cond_mask_i[4] = 1; cond_mask_i[8+4] = 1;
        cond_mask_i[5] = 1; cond_mask_i[16+5] = 1;
        flags_i[9] = 1; flags_i[3] = 1;
        apply_and_check("R7 both true");
        chk("R7 slots4/5", {22'h0, run_o[5:4]}, 24'h2);
        flags_i[3] = 0;
        apply_and_check("R7 one false");
        chk("R7 slot5 off", {23'h0, run_o[5]}, 24'h0);

        // R8: group literals.
        clear_in(); brk_i = 8'hFF;
        apply_and_check("R8 short all breaks");
        chk("R8 literal", grp_o, {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0});
        long_hdr_i = 1; brk_i = 8'b1010_0100;
        apply_and_check("R8 long");
        chk("R8 long literal", grp_o, {3'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0});

        // R2/R3/R8: exhaustive over shape, last slot and break mask.
        clear_in();
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < 8; l++)
                for (int b = 0; b < 256; b++) begin
                    long_hdr_i = f[0]; last_slot_i = 3'(l); brk_i = 8'(b);
                    apply_and_check("R2/R3/R8 sweep");
                end

        // R4/R5/R6/R7: pseudo-random walk over the predicate fields.
        lcg = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223; flags_i = lcg[31:16];
            long_hdr_i = lcg[5]; last_slot_i = lcg[10:8];
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            cond_sel_i = lcg[31:20]; cond_inv_i = lcg[6:4]; brk_i = lcg[15:8];
            lcg = lcg * 32'd1664525 + 32'd1013904223; cond_mask_i = lcg[31:8];
            apply_and_check("R4/R5/R6/R7 walk");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(5 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule